// File: doc/BRIEF.md
# Issue-Stage Hazard Interlock for Unequal-Length Execution Paths

This block sits beside the decode stage of an in-order pipeline whose floating-point work runs down paths of different depth: a pipelined adder, a longer pipelined multiplier, and a divider that takes one operation at a time. Because a short operation issued later can finish before a long one issued earlier, results complete out of order. The interlock holds the decoding instruction back until it can leave without reading a stale value, without letting an older write land after a younger one to the same register, without a second divide entering a busy divider, and without two results competing for the single write-back port in the same cycle.

It keeps a record of every in-flight instruction that writes a register. For each pipelined path this record is a shift chain with one entry per stage, holding the destination register. It also keeps a small write-back reservation vector, and runs a divider controller with three states. Each cycle it compares the decoding instruction's sources and destination against that record and raises `stall`. When the decoding instruction is valid and not stalled, `issue` is raised and the instruction is entered into the record on the next clock edge. Execution stages never stall, so every record advances by one stage per clock whether or not anything issues.

The divider controller has the states DV_IDLE (no divide in flight), DV_BUSY (a divide occupies any stage except its final one) and DV_LAST (a divide is in its final stage). Its transitions are: DV_IDLE to DV_BUSY when a divide issues; DV_BUSY to DV_LAST when its remaining-cycle count reaches two; DV_BUSY to itself otherwise; DV_LAST to DV_BUSY when a new divide issues in that cycle; DV_LAST to DV_IDLE otherwise.

Top module: `hz_interlock`

## Requirements
- R1: After reset (active-low `rst_n`, asynchronous) nothing is in flight. With `id_valid` low both `stall` and `issue` are 0. The first valid instruction that has no conflict issues in the cycle it is presented. Any record made before reset is forgotten.
- R2: A source register is compared with the destination of every in-flight instruction that is not yet in its unit's final stage. A match stalls. With `id_unit` encoded 0 = integer (1 stage), 1 = add (ADD_LAT stages), 2 = multiply (MUL_LAT stages) and 3 = divide (DIV_LAT stages), a consumer issued right after its producer therefore issues 1, ADD_LAT, MUL_LAT or DIV_LAT cycles after the producer. For the defaults this is 1, 4, 7 or 24 cycles. Both source operands are checked.
- R3: The decoding destination is compared with the destination of every add, multiply and divide instruction in any of its stages, including the final one. A match stalls until that instruction has left its final stage.
- R4: A divide stalls while an earlier divide is in any divider stage other than the final one. A divide may issue in the cycle the previous one is in its final stage.
- R5: An instruction of latency L that writes a register and is issued in cycle t writes back in cycle t+L. It stalls if an earlier register-writing instruction writes back in that same cycle.
- R6: A register identifier is 6 bits. Bit 5 selects the file (1 = floating-point, 0 = integer) and bits 4:0 give the index. Registers with the same index in different files never match.
- R7: Integer register 0 (identifier 6'h00) never causes a read-after-write or write-after-write stall.
- R8: `issue` is `id_valid` and not `stall`. With `id_valid` low nothing is recorded. An operand whose enable bit (`id_src1_vld`, `id_src2_vld`, `id_dst_vld`) is low takes part in no comparison, and an instruction with no destination reserves no write-back slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_unit | input | 2 | Execution unit: 0 integer, 1 add, 2 multiply, 3 divide |
| id_src1_vld | input | 1 | First source operand is used |
| id_src1 | input | 6 | First source register identifier |
| id_src2_vld | input | 1 | Second source operand is used |
| id_src2 | input | 6 | Second source register identifier |
| id_dst_vld | input | 1 | Instruction writes a register |
| id_dst | input | 6 | Destination register identifier |
| stall | output | 1 | Decoding instruction must wait this cycle |
| issue | output | 1 | Decoding instruction leaves decode at the next edge |

## Verification
`stall` and `issue` are combinational on the decoding fields and the state. They are therefore due in the same cycle an instruction is presented, and the bench reads them one time unit after the falling edge on which it changed its inputs. An issued instruction first affects the comparisons one clock later, in stage 1. It reaches its unit's final stage L cycles after issue, and its write-back reservation expires on that same cycle. The expected stall count of each instruction is worked out from those offsets. The bench counts the falling edges an instruction waits before `issue` and compares that count with the expected value. The next instruction is presented in the cycle right after the issue edge, so the offsets in the table hold exactly.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int IDX_W = 5;
    localparam int RID_W = IDX_W + 1;

    typedef logic [RID_W-1:0] rid_t;

    typedef enum logic [1:0] {
        U_INT  = 2'd0,
        U_FADD = 2'd1,
        U_FMUL = 2'd2,
        U_FDIV = 2'd3
    } unit_e;

    // True when both operands are live and name the same register,
    // except the hard-wired integer zero register.
    function automatic logic rid_hit(input logic a_vld, input rid_t a,
                                     input logic b_vld, input rid_t b);
        return a_vld && b_vld && (a == b) && (a != '0);
    endfunction
endpackage

// File: rtl/hz_pipe_track.sv
module hz_pipe_track
    import hz_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  rid_t push_dst,
    input  logic s1_vld,
    input  rid_t s1,
    input  logic s2_vld,
    input  rid_t s2,
    input  logic d_vld,
    input  rid_t d,
    output logic raw_hit,
    output logic waw_hit
);
    logic [DEPTH-1:0] occ;
    rid_t             tag [DEPTH];
    logic [DEPTH-1:0] raw_v;
    logic [DEPTH-1:0] waw_v;

    // Stages advance every cycle; a non-issuing cycle inserts a bubble.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
            for (int k = 0; k < DEPTH; k++) tag[k] <= '0;
        end else begin
            occ    <= {occ[DEPTH-2:0], push};
            tag[0] <= push_dst;
            for (int k = 1; k < DEPTH; k++) tag[k] <= tag[k-1];
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        assign waw_v[k] = rid_hit(occ[k], tag[k], d_vld, d);
        if (k < DEPTH - 1) begin : g_early
            assign raw_v[k] = rid_hit(occ[k], tag[k], s1_vld, s1)
                            | rid_hit(occ[k], tag[k], s2_vld, s2);
        end else begin : g_final
            // Final stage forwards its result: no read dependency.
            assign raw_v[k] = 1'b0;
        end
    end

    assign raw_hit = |raw_v;
    assign waw_hit = |waw_v;
endmodule

// File: rtl/hz_wb_sched.sv
module hz_wb_sched #(
    parameter int SPAN  = 7,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [LAT_W-1:0] set_lat,
    input  logic [LAT_W-1:0] query_lat,
    output logic             taken
);
    // slot[k] set: a write-back is booked k cycles from now.
    logic [SPAN:1] slot;
    logic [SPAN:1] slot_nxt;

    always_comb begin
        slot_nxt = {1'b0, slot[SPAN:2]};
        for (int k = 1; k < SPAN; k++) begin
            if (set_en && set_lat == LAT_W'(k + 1)) slot_nxt[k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot <= '0;
        else        slot <= slot_nxt;
    end

    always_comb begin
        taken = 1'b0;
        for (int k = 1; k <= SPAN; k++) begin
            if (query_lat == LAT_W'(k)) taken = slot[k];
        end
    end
endmodule

// File: rtl/hz_div_ctrl.sv
module hz_div_ctrl
    import hz_pkg::*;
#(
    parameter int DIV_LAT = 24,
    parameter int LAT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             s1_vld,
    input  rid_t             s1,
    input  logic             s2_vld,
    input  rid_t             s2,
    input  logic             d_vld,
    input  rid_t             d,
    input  logic [LAT_W-1:0] query_lat,
    output logic             unit_busy,
    output logic             raw_hit,
    output logic             waw_hit,
    output logic             wb_hit
);
    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_BUSY = 2'd1,
        DV_LAST = 2'd2
    } dv_state_e;

    dv_state_e        state, state_nxt;
    logic [LAT_W-1:0] cnt, cnt_nxt;   // cycles until its write-back, plus one
    rid_t             dst_q;
    logic             dvld_q;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            DV_IDLE: begin
                if (start) begin
                    state_nxt = DV_BUSY;
                    cnt_nxt   = LAT_W'(DIV_LAT);
                end
            end
            DV_BUSY: begin
                cnt_nxt   = cnt - 1'b1;
                state_nxt = (cnt == LAT_W'(2)) ? DV_LAST : DV_BUSY;
            end
            DV_LAST: begin
                if (start) begin
                    state_nxt = DV_BUSY;
                    cnt_nxt   = LAT_W'(DIV_LAT);
                end else begin
                    state_nxt = DV_IDLE;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = DV_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= DV_IDLE;
            cnt    <= '0;
            dst_q  <= '0;
            dvld_q <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (start) begin
                dst_q  <= d;
                dvld_q <= d_vld;
            end
        end
    end

    always_comb begin
        unit_busy = 1'b0;
        raw_hit   = 1'b0;
        waw_hit   = 1'b0;
        wb_hit    = 1'b0;
        unique case (state)
            DV_IDLE: ;
            DV_BUSY: begin
                unit_busy = 1'b1;
                raw_hit   = rid_hit(dvld_q, dst_q, s1_vld, s1)
                          | rid_hit(dvld_q, dst_q, s2_vld, s2);
                waw_hit   = rid_hit(dvld_q, dst_q, d_vld, d);
                wb_hit    = dvld_q && (cnt == query_lat + 1'b1);
            end
            DV_LAST: begin
                waw_hit   = rid_hit(dvld_q, dst_q, d_vld, d);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 7,
    parameter int DIV_LAT = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [1:0]       id_unit,
    input  logic             id_src1_vld,
    input  logic [RID_W-1:0] id_src1,
    input  logic             id_src2_vld,
    input  logic [RID_W-1:0] id_src2,
    input  logic             id_dst_vld,
    input  logic [RID_W-1:0] id_dst,
    output logic             stall,
    output logic             issue
);
    localparam int LAT_W = $clog2(DIV_LAT + 2);

    unit_e            unit;
    logic [LAT_W-1:0] lat;
    logic             add_raw, add_waw, mul_raw, mul_waw;
    logic             div_busy, div_raw, div_waw, div_wb;
    logic             sched_taken, wb_clash, div_block;

    assign unit = unit_e'(id_unit);

    always_comb begin
        unique case (unit)
            U_INT:   lat = LAT_W'(1);
            U_FADD:  lat = LAT_W'(ADD_LAT);
            U_FMUL:  lat = LAT_W'(MUL_LAT);
            U_FDIV:  lat = LAT_W'(DIV_LAT);
            default: lat = LAT_W'(1);
        endcase
    end

    hz_pipe_track #(.DEPTH(ADD_LAT)) u_add (
        .clk(clk), .rst_n(rst_n),
        .push(issue && unit == U_FADD && id_dst_vld), .push_dst(id_dst),
        .s1_vld(id_src1_vld), .s1(id_src1), .s2_vld(id_src2_vld), .s2(id_src2),
        .d_vld(id_dst_vld), .d(id_dst),
        .raw_hit(add_raw), .waw_hit(add_waw)
    );

    hz_pipe_track #(.DEPTH(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .push(issue && unit == U_FMUL && id_dst_vld), .push_dst(id_dst),
        .s1_vld(id_src1_vld), .s1(id_src1), .s2_vld(id_src2_vld), .s2(id_src2),
        .d_vld(id_dst_vld), .d(id_dst),
        .raw_hit(mul_raw), .waw_hit(mul_waw)
    );

    hz_div_ctrl #(.DIV_LAT(DIV_LAT), .LAT_W(LAT_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .start(issue && unit == U_FDIV),
        .s1_vld(id_src1_vld), .s1(id_src1), .s2_vld(id_src2_vld), .s2(id_src2),
        .d_vld(id_dst_vld), .d(id_dst), .query_lat(lat),
        .unit_busy(div_busy), .raw_hit(div_raw), .waw_hit(div_waw), .wb_hit(div_wb)
    );

    // Divide latency lies beyond the pipelined span, so the divider's own
    // counter guards its write-back slot.
    hz_wb_sched #(.SPAN(MUL_LAT), .LAT_W(LAT_W)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .set_en(issue && id_dst_vld && unit != U_FDIV),
        .set_lat(lat), .query_lat(lat), .taken(sched_taken)
    );

    assign wb_clash  = id_dst_vld && (sched_taken || div_wb);
    assign div_block = (unit == U_FDIV) && div_busy;
    assign stall     = id_valid && (add_raw || mul_raw || div_raw ||
                                    add_waw || mul_waw || div_waw ||
                                    wb_clash || div_block);
    assign issue     = id_valid && !stall;
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
    import hz_pkg::*;
#(
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic [1:0]       id_unit,
    input logic             id_src1_vld,
    input logic [RID_W-1:0] id_src1,
    input logic             id_dst_vld,
    input logic [RID_W-1:0] id_dst,
    input logic             stall,
    input logic             issue
);
    localparam int GAP = MUL_LAT - ADD_LAT;

    logic [3:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
    end

    // R2: a reader right behind an add producer must wait
    p_raw_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && id_unit == U_FADD && id_dst_vld && id_dst != '0)
        |=> (!(id_valid && id_src1_vld && id_src1 == $past(id_dst)) || stall));

    // R3: a second writer of a multiply destination must wait
    p_waw_mul_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && id_unit == U_FMUL && id_dst_vld && id_dst != '0)
        |=> (!(id_valid && id_dst_vld && id_dst == $past(id_dst)) || stall));

    // R4: two divides never issue on consecutive cycles
    p_div_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && id_unit == U_FDIV) |=> !(issue && id_unit == U_FDIV));

    // R5: an add never lands on the write-back cycle of a multiply issued GAP earlier
    p_wb_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 4'(GAP) && issue && id_unit == U_FADD && id_dst_vld)
        |-> !$past(issue && id_unit == U_FMUL && id_dst_vld, GAP));

    // R8: an idle decode stage neither issues nor stalls
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !(issue || stall));
endmodule

bind hz_interlock hz_interlock_chk #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
    .id_src1_vld(id_src1_vld), .id_src1(id_src1),
    .id_dst_vld(id_dst_vld), .id_dst(id_dst),
    .stall(stall), .issue(issue)
);

// File: tb/hz_interlock_test.sv
`timescale 1ns/1ps
module hz_interlock_test;
    typedef struct packed {
        logic [1:0] unit;
        logic       s1v;
        logic [5:0] s1;
        logic       s2v;
        logic [5:0] s2;
        logic       dv;
        logic [5:0] d;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // unit: 0 int, 1 add, 2 mul, 3 div; 6'h2n is fp register n, 6'h0n integer.
    // exp = falling edges spent waiting before issue.
    localparam vec_t VECS [22] = '{
        '{2'd1, 1'b1, 6'h22, 1'b1, 6'h23, 1'b1, 6'h21, 8'd0,  4'd1},
        '{2'd1, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h24, 8'd3,  4'd2},
        '{2'd2, 1'b1, 6'h26, 1'b1, 6'h27, 1'b1, 6'h25, 8'd0,  4'd5},
        '{2'd1, 1'b1, 6'h29, 1'b1, 6'h2a, 1'b1, 6'h28, 8'd0,  4'd5},
        '{2'd1, 1'b1, 6'h2c, 1'b1, 6'h2d, 1'b1, 6'h2b, 8'd0,  4'd5},
        '{2'd1, 1'b1, 6'h2c, 1'b1, 6'h2d, 1'b1, 6'h2e, 8'd1,  4'd5},
        '{2'd1, 1'b1, 6'h25, 1'b1, 6'h22, 1'b1, 6'h2f, 8'd2,  4'd2},
        '{2'd0, 1'b1, 6'h02, 1'b1, 6'h03, 1'b1, 6'h01, 8'd0,  4'd2},
        '{2'd0, 1'b1, 6'h01, 1'b1, 6'h01, 1'b1, 6'h04, 8'd0,  4'd2},
        '{2'd2, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h00, 8'd0,  4'd7},
        '{2'd0, 1'b1, 6'h00, 1'b1, 6'h00, 1'b1, 6'h06, 8'd0,  4'd7},
        '{2'd2, 1'b1, 6'h31, 1'b1, 6'h32, 1'b1, 6'h30, 8'd0,  4'd3},
        '{2'd2, 1'b1, 6'h32, 1'b1, 6'h33, 1'b1, 6'h30, 8'd7,  4'd3},
        '{2'd3, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h34, 8'd0,  4'd4},
        '{2'd3, 1'b1, 6'h23, 1'b1, 6'h24, 1'b1, 6'h35, 8'd23, 4'd4},
        '{2'd1, 1'b1, 6'h35, 1'b1, 6'h22, 1'b1, 6'h36, 8'd23, 4'd2},
        '{2'd3, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h38, 8'd0,  4'd4},
        '{2'd1, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h38, 8'd24, 4'd3},
        '{2'd2, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h39, 8'd0,  4'd6},
        '{2'd0, 1'b1, 6'h19, 1'b1, 6'h19, 1'b1, 6'h08, 8'd0,  4'd6},
        '{2'd1, 1'b1, 6'h39, 1'b1, 6'h21, 1'b1, 6'h3a, 8'd5,  4'd2},
        '{2'd0, 1'b1, 6'h3a, 1'b0, 6'h00, 1'b0, 6'h00, 8'd3,  4'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid;
    logic [1:0] id_unit;
    logic       id_src1_vld, id_src2_vld, id_dst_vld;
    logic [5:0] id_src1, id_src2, id_dst;
    logic       stall, issue;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hz_interlock uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
        .id_src1_vld(id_src1_vld), .id_src1(id_src1),
        .id_src2_vld(id_src2_vld), .id_src2(id_src2),
        .id_dst_vld(id_dst_vld), .id_dst(id_dst),
        .stall(stall), .issue(issue)
    );

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R?";
        endcase
    endfunction

    function automatic vec_t mk(input logic [1:0] u, input logic a_v, input logic [5:0] a,
                                input logic b_v, input logic [5:0] b,
                                input logic c_v, input logic [5:0] c);
        vec_t v;
        v = '{u, a_v, a, b_v, b, c_v, c, 8'd0, 4'd0};
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the issue edge.
    task automatic run_instr(input vec_t v, output int waits, output bit issued);
        id_valid    = 1'b1;
        id_unit     = v.unit;
        id_src1_vld = v.s1v;  id_src1 = v.s1;
        id_src2_vld = v.s2v;  id_src2 = v.s2;
        id_dst_vld  = v.dv;   id_dst  = v.d;
        waits = 0;
        #1;
        while (stall === 1'b1 && waits < 300) begin
            waits++;
            @(negedge clk);
            #1;
        end
        issued = (issue === 1'b1);
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    task automatic expect_waits(input vec_t v, input int expw, input string tag);
        int  w;
        bit  ok;
        run_instr(v, w, ok);
        check(w == expw, tag, w, expw);
        check(ok, {tag, " issue"}, int'(ok), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        id_valid = 1'b0; id_unit = 2'd0;
        id_src1_vld = 1'b0; id_src1 = '0;
        id_src2_vld = 1'b0; id_src2 = '0;
        id_dst_vld  = 1'b0; id_dst  = '0;
        repeat (3) @(negedge clk);
        #1;
        check(stall === 1'b0 && issue === 1'b0, "R1 reset outputs", int'({stall, issue}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: instructions back to back, counting wait cycles.
        for (int i = 0; i < 22; i++) begin
            expect_waits(VECS[i], int'(VECS[i].exp),
                         $sformatf("%s vector %0d", rtag(VECS[i].req), i));
        end

        // R1: reset forgets an in-flight multiply
        expect_waits(mk(2'd2, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h2a), 0, "R1 pre-reset mul");
        rst_n = 1'b0;
        #1;
        check(stall === 1'b0 && issue === 1'b0, "R1 outputs in reset", int'({stall, issue}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_waits(mk(2'd1, 1'b1, 6'h2a, 1'b0, 6'h00, 1'b1, 6'h2b), 0, "R1 reader after reset");

        // R8: an invalid slot with a destination records nothing
        id_valid = 1'b0; id_unit = 2'd1; id_dst_vld = 1'b1; id_dst = 6'h3e;
        id_src1_vld = 1'b0; id_src2_vld = 1'b0;
        #1;
        check(stall === 1'b0 && issue === 1'b0, "R8 bubble outputs", int'({stall, issue}), 0);
        @(negedge clk);
        expect_waits(mk(2'd1, 1'b1, 6'h3e, 1'b0, 6'h00, 1'b1, 6'h3f), 0, "R8 reader of bubble dst");

        // R5: add whose write-back meets a divide's write-back
        expect_waits(mk(2'd3, 1'b1, 6'h21, 1'b1, 6'h22, 1'b1, 6'h3b), 0, "R5 divide issue");
        repeat (19) @(negedge clk);
        expect_waits(mk(2'd1, 1'b1, 6'h3d, 1'b0, 6'h00, 1'b1, 6'h3c), 1, "R5 add vs divide write-back");

        // R8: disabled operands are not compared; R2: second source is
        expect_waits(mk(2'd0, 1'b0, 6'h3c, 1'b0, 6'h3c, 1'b0, 6'h3c), 0, "R8 disabled operands");
        expect_waits(mk(2'd0, 1'b0, 6'h00, 1'b1, 6'h3c, 1'b0, 6'h00), 2, "R2 second source");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule